// File: doc/BRIEF.md
# Frequency-Locked Loop Lock Monitor

This block decides whether a frequency-locked loop has settled on its target. At the end of every comparison cycle the loop delivers an oscillator pulse count. The block subtracts the programmed multiplier target from that count to get a signed count error. It then applies a hysteresis rule with two error windows. A narrow acquire window must hold for a fixed number of consecutive samples before lock is declared. A wider hold window keeps lock once it has been reached.

From that decision the block drives four things:
- a lock status bit;
- a sticky flag that records unexpected loss of lock, cleared by a status read followed by a write of one;
- a select that asks the output clock divider for an extra halving until the first lock since the loop was engaged;
- a strobe that passes a count error to the loop filter. The strobe carries every sample while unlocked and a four-sample average once locked.

Deliberate clock stops and unexpected clock stops are handled differently. Only an unexpected stop marks the sticky flag, and it does so when the clock comes back.

Top module: `fll_lock_mon`

## Requirements
- R1: The count error is the pulse count minus the multiplier target, taken as a signed value that is one bit wider than the counts. While unlocked, every accepted sample produces a filter strobe that carries that error in the cycle after the sample.
- R2: Lock is declared in the cycle after the LOCK_SAMPLES-th consecutive sample whose error is strictly greater than the acquire minimum and strictly less than the acquire maximum. Errors equal to either bound do not count.
- R3: Before lock, any accepted sample outside the acquire window sets the consecutive-sample count back to zero.
- R4: While locked, an error inside the hold window, bounds included, keeps lock. An error above the hold maximum or below the hold minimum clears lock in the cycle after the sample.
- R5: Losing lock through R4 sets the sticky loss flag. When the loss-reset enable is high, the same event also pulses the reset request for one cycle.
- R6: The sticky flag clears only on a write of one that follows a status read, and only while the loss-reset enable is low. A write with no prior read leaves the flag set. A reset clears the flag.
- R7: The divide-select is high (divide by 2R) from reset or from mode entry until the first lock. It then stays low (divide by R), including after a later loss of lock, for as long as the mode stays engaged.
- R8: While locked, the filter strobe fires only on every fourth sample. It carries the sum of those four errors shifted right by two with sign extension.
- R9: A deliberate clock stop clears lock and leaves the sticky flag unchanged. An unexpected clock stop clears lock and sets the sticky flag in the cycle after the clock returns.
- R10: Leaving the engaged mode clears lock without setting the sticky flag and forgets the first-lock history.
- R11: After reset, lock, sticky flag, strobe and reset request are low, and the divide-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| engaged_i | input | 1 | Loop engaged on the external reference |
| cmp_valid_i | input | 1 | End-of-comparison-cycle strobe |
| pulse_cnt_i | input | CNT_W | Oscillator pulse count for the cycle |
| mult_tgt_i | input | CNT_W | Programmed multiplier target |
| acq_min_i | input | CNT_W+1 | Acquire window lower bound (signed, exclusive) |
| acq_max_i | input | CNT_W+1 | Acquire window upper bound (signed, exclusive) |
| hold_min_i | input | CNT_W+1 | Hold window lower bound (signed, inclusive) |
| hold_max_i | input | CNT_W+1 | Hold window upper bound (signed, inclusive) |
| clk_off_i | input | 1 | Loop clocks stopped |
| off_planned_i | input | 1 | Current clock stop is deliberate |
| stat_rd_i | input | 1 | Status register read strobe |
| flag_wr1_i | input | 1 | Write of one to the flag bit |
| lol_rst_en_i | input | 1 | Loss of lock requests a reset |
| locked_o | output | 1 | Lock status |
| lol_flag_o | output | 1 | Sticky unexpected loss-of-lock flag |
| div2r_o | output | 1 | 1 = divide by 2R, 0 = divide by R |
| lol_rst_req_o | output | 1 | One-cycle reset request on loss |
| filt_upd_o | output | 1 | Loop filter update strobe |
| filt_err_o | output | CNT_W+1 | Error value handed to the filter (signed) |

## Verification
The bench places errors exactly on the acquire bounds. A design with inclusive comparisons would lock one pass early there. It also checks that a single out-of-window sample restarts acquisition, so a design that only pauses the count is caught by locking too soon. It feeds a locked average with a negative sum whose shift needs flooring, so a logical shift or a missing sign extension gives a large positive value. Other cases cover a loss of lock that must not restore the extra halving, a flag write with no prior read, and the two kinds of clock stop. A design that mixes these up shows the wrong divide-select or a wrong sticky-flag value.

// File: rtl/fll_lock_pkg.sv
package fll_lock_pkg;
  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;
endpackage

// File: rtl/fll_err_calc.sv
module fll_err_calc #(
  parameter int CNT_W = 12,
  localparam int ERR_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]        pulse_cnt_i,
  input  logic [CNT_W-1:0]        mult_tgt_i,
  input  logic signed [ERR_W-1:0] acq_min_i,
  input  logic signed [ERR_W-1:0] acq_max_i,
  input  logic signed [ERR_W-1:0] hold_min_i,
  input  logic signed [ERR_W-1:0] hold_max_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    in_acq_o,
  output logic                    in_hold_o
);
  always_comb begin
    err_o     = $signed({1'b0, pulse_cnt_i}) - $signed({1'b0, mult_tgt_i});
    // acquire bounds exclusive, hold bounds inclusive
    in_acq_o  = (err_o > acq_min_i) && (err_o < acq_max_i);
    in_hold_o = (err_o >= hold_min_i) && (err_o <= hold_max_i);
  end
endmodule

// File: rtl/fll_lock_fsm.sv
module fll_lock_fsm
  import fll_lock_pkg::*;
#(
  parameter int LOCK_SAMPLES = 4,
  localparam int SC_W = $clog2(LOCK_SAMPLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic engaged_i,
  input  logic clk_off_i,
  input  logic off_planned_i,
  input  logic smp_v_i,
  input  logic in_acq_i,
  input  logic in_hold_i,
  input  logic stat_rd_i,
  input  logic flag_wr1_i,
  input  logic lol_rst_en_i,
  output logic locked_o,
  output logic lol_flag_o,
  output logic div2r_o,
  output logic lol_rst_req_o
);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(LOCK_SAMPLES - 1);

  lock_st_e        st_q, st_d;
  logic [SC_W-1:0] cnt_q, cnt_d;
  logic            ever_q, ever_d;
  logic            flag_q, rd_arm_q, off_q, unexp_q, req_q;
  logic            loss_evt, wake_evt, flag_set;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    ever_d   = ever_q;
    loss_evt = 1'b0;
    if (!engaged_i || clk_off_i) begin
      st_d  = ST_ACQ;
      cnt_d = '0;
      if (!engaged_i) ever_d = 1'b0;
    end else if (smp_v_i) begin
      unique case (st_q)
        ST_ACQ: begin
          if (!in_acq_i) begin
            cnt_d = '0;
          end else if (cnt_q == SC_LAST) begin
            st_d   = ST_LOCK;
            cnt_d  = '0;
            ever_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (!in_hold_i) begin
            st_d     = ST_ACQ;
            loss_evt = 1'b1;
          end
        end
        default: st_d = ST_ACQ;
      endcase
    end
  end

  assign wake_evt = off_q && !clk_off_i && unexp_q;
  assign flag_set = loss_evt || wake_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_ACQ;
      cnt_q    <= '0;
      ever_q   <= 1'b0;
      flag_q   <= 1'b0;
      rd_arm_q <= 1'b0;
      off_q    <= 1'b0;
      unexp_q  <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ever_q <= ever_d;
      off_q  <= clk_off_i;
      req_q  <= flag_set && lol_rst_en_i;
      if (clk_off_i && !off_planned_i) unexp_q <= 1'b1;
      else if (!clk_off_i)             unexp_q <= 1'b0;
      if (flag_wr1_i)     rd_arm_q <= 1'b0;
      else if (stat_rd_i) rd_arm_q <= 1'b1;
      // set wins over a simultaneous clear
      if (flag_set) flag_q <= 1'b1;
      else if (flag_wr1_i && rd_arm_q && !lol_rst_en_i) flag_q <= 1'b0;
    end
  end

  assign locked_o      = (st_q == ST_LOCK);
  assign lol_flag_o    = flag_q;
  assign div2r_o       = !ever_q;
  assign lol_rst_req_o = req_q;

  // R2
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(smp_v_i) && $past(in_acq_i));
  // R5
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $fell(locked_o) || $past(unexp_q));
  // R6
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(flag_wr1_i) && !$past(lol_rst_en_i));
  // R7
  first_lock_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div2r_o) |-> !$past(engaged_i));
endmodule

// File: rtl/fll_filt_strobe.sv
module fll_filt_strobe #(
  parameter int CNT_W = 12,
  localparam int ERR_W = CNT_W + 1,
  localparam int ACC_W = ERR_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_v_i,
  input  logic                    locked_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    upd_o,
  output logic signed [ERR_W-1:0] upd_err_o
);
  logic [1:0]              ph_q;
  logic signed [ACC_W-1:0] acc_q, sum_w, avg_w;

  assign sum_w = acc_q + {{2{err_i[ERR_W-1]}}, err_i};
  assign avg_w = sum_w >>> 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      acc_q     <= '0;
      upd_o     <= 1'b0;
      upd_err_o <= '0;
    end else begin
      upd_o <= 1'b0;
      if (!locked_i) begin
        ph_q  <= '0;
        acc_q <= '0;
        if (smp_v_i) begin
          upd_o     <= 1'b1;
          upd_err_o <= err_i;
        end
      end else if (smp_v_i) begin
        if (ph_q == 2'd3) begin
          upd_o     <= 1'b1;
          upd_err_o <= avg_w[ERR_W-1:0];
          ph_q      <= '0;
          acc_q     <= '0;
        end else begin
          ph_q  <= ph_q + 2'd1;
          acc_q <= sum_w;
        end
      end
    end
  end

  // R1
  upd_follows_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(smp_v_i));
  // R8
  locked_thin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && $past(locked_i)) |=> !upd_o);
endmodule

// File: rtl/fll_lock_mon.sv
module fll_lock_mon #(
  parameter int CNT_W        = 12,
  parameter int LOCK_SAMPLES = 4,
  localparam int ERR_W = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    engaged_i,
  input  logic                    cmp_valid_i,
  input  logic [CNT_W-1:0]        pulse_cnt_i,
  input  logic [CNT_W-1:0]        mult_tgt_i,
  input  logic signed [ERR_W-1:0] acq_min_i,
  input  logic signed [ERR_W-1:0] acq_max_i,
  input  logic signed [ERR_W-1:0] hold_min_i,
  input  logic signed [ERR_W-1:0] hold_max_i,
  input  logic                    clk_off_i,
  input  logic                    off_planned_i,
  input  logic                    stat_rd_i,
  input  logic                    flag_wr1_i,
  input  logic                    lol_rst_en_i,
  output logic                    locked_o,
  output logic                    lol_flag_o,
  output logic                    div2r_o,
  output logic                    lol_rst_req_o,
  output logic                    filt_upd_o,
  output logic signed [ERR_W-1:0] filt_err_o
);
  logic signed [ERR_W-1:0] err;
  logic in_acq, in_hold, smp_v;

  assign smp_v = cmp_valid_i && engaged_i && !clk_off_i;

  fll_err_calc #(.CNT_W(CNT_W)) u_err (
    .pulse_cnt_i(pulse_cnt_i), .mult_tgt_i(mult_tgt_i),
    .acq_min_i(acq_min_i), .acq_max_i(acq_max_i),
    .hold_min_i(hold_min_i), .hold_max_i(hold_max_i),
    .err_o(err), .in_acq_o(in_acq), .in_hold_o(in_hold)
  );

  fll_lock_fsm #(.LOCK_SAMPLES(LOCK_SAMPLES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .engaged_i(engaged_i),
    .clk_off_i(clk_off_i), .off_planned_i(off_planned_i),
    .smp_v_i(smp_v), .in_acq_i(in_acq), .in_hold_i(in_hold),
    .stat_rd_i(stat_rd_i), .flag_wr1_i(flag_wr1_i), .lol_rst_en_i(lol_rst_en_i),
    .locked_o(locked_o), .lol_flag_o(lol_flag_o), .div2r_o(div2r_o),
    .lol_rst_req_o(lol_rst_req_o)
  );

  fll_filt_strobe #(.CNT_W(CNT_W)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_v_i(smp_v), .locked_i(locked_o),
    .err_i(err), .upd_o(filt_upd_o), .upd_err_o(filt_err_o)
  );
endmodule

// File: tb/fll_lock_mon_tb.sv
module fll_lock_mon_tb;
  localparam int CNT_W = 12;
  localparam int ERR_W = CNT_W + 1;
  localparam int NS    = 4;
  localparam int TGT   = 500;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic engaged_i = 1'b0, cmp_valid_i = 1'b0;
  logic [CNT_W-1:0] pulse_cnt_i = TGT, mult_tgt_i = TGT;
  logic signed [ERR_W-1:0] acq_min_i = -4, acq_max_i = 4, hold_min_i = -16, hold_max_i = 16;
  logic clk_off_i = 1'b0, off_planned_i = 1'b0, stat_rd_i = 1'b0, flag_wr1_i = 1'b0, lol_rst_en_i = 1'b0;
  logic locked_o, lol_flag_o, div2r_o, lol_rst_req_o, filt_upd_o;
  logic signed [ERR_W-1:0] filt_err_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  fll_lock_mon #(.CNT_W(CNT_W), .LOCK_SAMPLES(NS)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; engaged_i = 1'b0; cmp_valid_i = 1'b0; clk_off_i = 1'b0;
    off_planned_i = 1'b0; stat_rd_i = 1'b0; flag_wr1_i = 1'b0; lol_rst_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one sample; outputs are observed at the following negedge
  task automatic smp(input int e);
    pulse_cnt_i = CNT_W'(TGT + e);
    cmp_valid_i = 1'b1;
    @(negedge clk_i);
    cmp_valid_i = 1'b0;
  endtask

  task automatic get_lock();
    engaged_i = 1'b1;
    for (int i = 0; i < NS; i++) smp(0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 locked", locked_o, 0);
    chk("R11 flag", lol_flag_o, 0);
    chk("R11 div2r", div2r_o, 1);
    chk("R11 upd", filt_upd_o, 0);
    chk("R11 req", lol_rst_req_o, 0);
  endtask

  task automatic t_acquire();
    do_reset();
    engaged_i = 1'b1;
    for (int i = 0; i < NS - 1; i++) begin
      smp(3 - i);
      chk("R1 upd", filt_upd_o, 1);
      chk("R1 err", filt_err_o, 3 - i);
      chk("R2 not yet", locked_o, 0);
    end
    smp(-3);
    chk("R2 lock", locked_o, 1);
    chk("R7 div R", div2r_o, 0);
  endtask

  task automatic t_bounds();
    do_reset();
    engaged_i = 1'b1;
    for (int i = 0; i < NS - 1; i++) smp(0);
    smp(4);
    chk("R2 upper bound excl", locked_o, 0);
    for (int i = 0; i < NS - 1; i++) smp(0);
    chk("R3 restart", locked_o, 0);
    smp(-4);
    chk("R3 lower bound restart", locked_o, 0);
    for (int i = 0; i < NS; i++) smp(0);
    chk("R2 relock", locked_o, 1);
    chk("R7 div2r before relock", div2r_o, 0);
  endtask

  task automatic t_hold_avg();
    do_reset();
    get_lock();
    smp(-3); chk("R8 thin1", filt_upd_o, 0);
    smp(-2); chk("R8 thin2", filt_upd_o, 0);
    smp(-1); chk("R8 thin3", filt_upd_o, 0);
    smp(1);
    chk("R8 avg strobe", filt_upd_o, 1);
    chk("R8 avg value", filt_err_o, -2);
    smp(16); chk("R4 hold max incl", locked_o, 1);
    smp(-16); chk("R4 hold min incl", locked_o, 1);
    chk("R5 no flag yet", lol_flag_o, 0);
    smp(17);
    chk("R4 drop", locked_o, 0);
    chk("R5 flag", lol_flag_o, 1);
    chk("R5 no req when disabled", lol_rst_req_o, 0);
    chk("R7 stays R", div2r_o, 0);
  endtask

  task automatic t_clear();
    do_reset();
    get_lock();
    smp(-17);
    chk("R5 flag low side", lol_flag_o, 1);
    flag_wr1_i = 1'b1; @(negedge clk_i); flag_wr1_i = 1'b0; @(negedge clk_i);
    chk("R6 write w/o read", lol_flag_o, 1);
    stat_rd_i = 1'b1; @(negedge clk_i); stat_rd_i = 1'b0;
    flag_wr1_i = 1'b1; @(negedge clk_i); flag_wr1_i = 1'b0;
    chk("R6 cleared", lol_flag_o, 0);
    lol_rst_en_i = 1'b1;
    for (int i = 0; i < NS; i++) smp(0);
    smp(30);
    chk("R5 req pulse", lol_rst_req_o, 1);
    @(negedge clk_i);
    chk("R5 req one cycle", lol_rst_req_o, 0);
    stat_rd_i = 1'b1; @(negedge clk_i); stat_rd_i = 1'b0;
    flag_wr1_i = 1'b1; @(negedge clk_i); flag_wr1_i = 1'b0;
    chk("R6 no clear when reset enabled", lol_flag_o, 1);
    do_reset();
    chk("R6 reset clears", lol_flag_o, 0);
  endtask

  task automatic t_stop();
    do_reset();
    get_lock();
    off_planned_i = 1'b1; clk_off_i = 1'b1;
    @(negedge clk_i);
    chk("R9 planned unlock", locked_o, 0);
    clk_off_i = 1'b0; @(negedge clk_i); @(negedge clk_i);
    chk("R9 planned flag", lol_flag_o, 0);
    off_planned_i = 1'b0;
    for (int i = 0; i < NS; i++) smp(0);
    chk("R9 relock", locked_o, 1);
    clk_off_i = 1'b1; @(negedge clk_i); @(negedge clk_i);
    chk("R9 unexp unlock", locked_o, 0);
    chk("R9 flag waits wake", lol_flag_o, 0);
    clk_off_i = 1'b0; @(negedge clk_i);
    chk("R9 flag on wake", lol_flag_o, 1);
  endtask

  task automatic t_mode();
    do_reset();
    get_lock();
    engaged_i = 1'b0;
    @(negedge clk_i);
    chk("R10 unlock", locked_o, 0);
    chk("R10 no flag", lol_flag_o, 0);
    chk("R7 div2R again", div2r_o, 1);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_bounds();
    t_hold_avg();
    t_clear();
    t_stop();
    t_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule